// File: doc/BRIEF.md
# Remappable Vectored Interrupt Controller

This block collects interrupt requests from a set of primary sources and from a secondary group whose summary feeds primary source 0. It records each rising request edge in a pending bit, which stays set until software clears it. A per-source enable mask is changed only by writing ones to separate set and clear registers. Software reads back the pending bits and the enables on a small 32-bit register bus.

A remap table assigns a source to each priority channel, so software chooses which source wins. A lower channel number is more urgent. A read-only index register returns the most urgent channel whose mapped source is pending and enabled. It returns the channel count, 40, when no channel requests. The single processor interrupt line is a registered copy of "index is not the sentinel".

The interrupt handler reads the index, services the source, and clears its pending bit. When the index is 0, the handler first services the secondary group. It clears the secondary pending bits, then clears primary bit 0.

Top module: `vic_remap`

## Requirements
- R1: After reset all pending bits and all enables are zero, the index reads 40, `irq_o` is low, and mapping entry n reads back n for every channel.
- R2: A 0-to-1 change on `pri_req[i]` sets primary pending bit i. A request held high sets it only once. Pending bits read at 0x00 (bits 0..31) and at 0x04 (sources 32..39 in bits 7:0).
- R3: Writing ones to 0x10 or 0x14 clears the selected pending bits, and zero bits leave bits unchanged. When a new request edge and a clear hit the same bit in one cycle, the bit ends up set.
- R4: Writing ones to 0x20 or 0x24 enables the selected sources, and writing ones to 0x30 or 0x34 disables them. Zero bits change nothing. The enable mask reads back at 0x20 and 0x24.
- R5: Register 0x40 returns, in bits 5:0, the lowest channel n whose mapped source is both pending and enabled. It returns 40 when no channel qualifies.
- R6: Entry n of the mapping table, at 0x200 + 4n, holds a 6-bit source number, and channel n takes its request from that source. An entry of 40 or more never requests.
- R7: The secondary group has pending bits at 0x80, write-one pending clear at 0x88, and an enable-set register at 0x90 that also reads back the mask. It has enable clear at 0x98, and a rising `sec_req` edge sets the matching secondary pending bit.
- R8: While any secondary source is both pending and enabled, primary pending bit 0 is set every cycle. Clearing bit 0 therefore only sticks once the secondary group is quiet.
- R9: `irq_o` is registered. It takes the value "index differs from 40" one clock after the pending, enable or mapping state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_req | input | 40 | Primary request lines |
| sec_req | input | 32 | Secondary request lines |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
The bench builds the controller with its default sizes: 40 primary sources, 32 secondary sources and a 12-bit address. These sizes make the index sentinel exactly 40, fill the upper pending and enable words with only eight live bits, and make the mapping table 40 entries. With them the bench reaches source 32 in the second word, an out-of-range mapping entry, and the cascade into primary source 0.

// File: rtl/vic_remap.sv
module vic_remap #(
  parameter int NPRI = 40,
  parameter int NSEC = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPRI-1:0] pri_req,
  input  logic [NSEC-1:0] sec_req,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o
);
  localparam int IDW  = $clog2(NPRI + 1);
  localparam int MAPN = 2 ** IDW;
  localparam logic [IDW-1:0] NONE = IDW'(NPRI);
  localparam logic [AW-4:0] G_PST = (AW-3)'(0);
  localparam logic [AW-4:0] G_PCL = (AW-3)'(2);
  localparam logic [AW-4:0] G_EST = (AW-3)'(4);
  localparam logic [AW-4:0] G_ECL = (AW-3)'(6);
  localparam logic [AW-4:0] G_IDX = (AW-3)'(8);
  localparam logic [AW-4:0] G_SST = (AW-3)'(16);
  localparam logic [AW-4:0] G_SCL = (AW-3)'(17);
  localparam logic [AW-4:0] G_SES = (AW-3)'(18);
  localparam logic [AW-4:0] G_SEC = (AW-3)'(19);

  logic [NPRI-1:0] pri_pend, pri_en, pri_req_q;
  logic [NSEC-1:0] sec_pend, sec_en, sec_req_q;
  logic [IDW-1:0]  map_q [NPRI];
  logic [IDW-1:0]  idx;
  logic [NPRI-1:0] chreq;

  wire             aligned = bus_addr[1:0] == 2'b00;
  wire [AW-4:0]    grp     = bus_addr[AW-1:3];
  wire             hi      = bus_addr[2];
  wire             wr      = bus_we && aligned;
  wire [NPRI-1:0]  wbits   = hi ? NPRI'({bus_wdata, 32'h0}) : NPRI'(bus_wdata);
  wire [NSEC-1:0]  wsec    = NSEC'(bus_wdata);
  wire [6:0]       map_idx = bus_addr[8:2];
  wire             map_hit = aligned && bus_addr[AW-1:9] == (AW-9)'(1) && 32'(map_idx) < NPRI;

  wire [NPRI-1:0]  pclr  = (wr && grp == G_PCL) ? wbits : '0;
  wire [NPRI-1:0]  eset  = (wr && grp == G_EST) ? wbits : '0;
  wire [NPRI-1:0]  eclr  = (wr && grp == G_ECL) ? wbits : '0;
  wire [NSEC-1:0]  sclr  = (wr && !hi && grp == G_SCL) ? wsec : '0;
  wire [NSEC-1:0]  seset = (wr && !hi && grp == G_SES) ? wsec : '0;
  wire [NSEC-1:0]  seclr = (wr && !hi && grp == G_SEC) ? wsec : '0;

  wire             sec_any = |(sec_pend & sec_en);
  wire [NPRI-1:0]  pri_rise = pri_req & ~pri_req_q;
  wire [NPRI-1:0]  pri_set  = pri_rise | NPRI'(sec_any);
  wire [NPRI-1:0]  act      = pri_pend & pri_en;
  wire [MAPN-1:0]  act_x    = MAPN'(act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_pend  <= '0;
      pri_en    <= '0;
      pri_req_q <= '0;
      sec_pend  <= '0;
      sec_en    <= '0;
      sec_req_q <= '0;
      irq_o     <= 1'b0;
      for (int i = 0; i < NPRI; i++) map_q[i] <= IDW'(i);
    end else begin
      pri_req_q <= pri_req;
      sec_req_q <= sec_req;
      pri_pend  <= (pri_pend & ~pclr) | pri_set;
      pri_en    <= (pri_en | eset) & ~eclr;
      sec_pend  <= (sec_pend & ~sclr) | (sec_req & ~sec_req_q);
      sec_en    <= (sec_en | seset) & ~seclr;
      irq_o     <= idx != NONE;
      if (bus_we && map_hit) map_q[map_idx[IDW-1:0]] <= bus_wdata[IDW-1:0];
    end
  end

  for (genvar n = 0; n < NPRI; n++) begin : g_ch
    assign chreq[n] = act_x[map_q[n]];
  end

  always_comb begin
    idx = NONE;
    for (int n = NPRI - 1; n >= 0; n--)
      if (chreq[n]) idx = IDW'(n);
  end

  wire [63:0] pend64 = 64'(pri_pend);
  wire [63:0] en64   = 64'(pri_en);

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (grp)
        G_PST, G_PCL: bus_rdata = hi ? pend64[63:32] : pend64[31:0];
        G_EST, G_ECL: bus_rdata = hi ? en64[63:32] : en64[31:0];
        G_IDX:        if (!hi) bus_rdata = 32'(idx);
        G_SST, G_SCL: if (!hi) bus_rdata = 32'(sec_pend);
        G_SES, G_SEC: if (!hi) bus_rdata = 32'(sec_en);
        default:      if (map_hit) bus_rdata = 32'(map_q[map_idx[IDW-1:0]]);
      endcase
    end
  end

  // R2 R3
  edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pri_rise) |=> ((pri_pend & $past(pri_rise)) == $past(pri_rise)));

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eset) |=> ((pri_en & $past(eset)) == $past(eset)));

  // R8
  cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_any |=> pri_pend[0]);

  // R5
  idx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != NONE) |-> act_x[map_q[idx]]);

  // R5
  idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != NONE) |-> ((chreq & ((NPRI'(1) << idx) - NPRI'(1))) == '0));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|act));
endmodule

// File: tb/tb_vic_remap.sv
module tb_vic_remap;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;
  // {read?, addr[11:0], data/expected[31:0]}
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 12'h020, 32'h0000_0005}, {1'b1, 12'h020, 32'h0000_0005},
    {1'b0, 12'h024, 32'h0000_0081}, {1'b1, 12'h024, 32'h0000_0081},
    {1'b0, 12'h030, 32'h0000_0001}, {1'b1, 12'h020, 32'h0000_0004},
    {1'b0, 12'h030, 32'h0000_0000}, {1'b1, 12'h020, 32'h0000_0004},
    {1'b0, 12'h034, 32'h0000_0080}, {1'b1, 12'h024, 32'h0000_0001},
    {1'b0, 12'h210, 32'h0000_0003}, {1'b1, 12'h210, 32'h0000_0003},
    {1'b1, 12'h214, 32'h0000_0005}, {1'b0, 12'h090, 32'h0000_00F0},
    {1'b0, 12'h098, 32'h0000_0010}, {1'b1, 12'h090, 32'h0000_00E0},
    {1'b1, 12'h040, 32'h0000_0028}
  };

  logic        clk = 0, rst_n = 0, we = 0;
  logic [39:0] pri_req = '0;
  logic [31:0] sec_req = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          errors = 0, checks = 0;

  vic_remap dut (.clk(clk), .rst_n(rst_n), .pri_req(pri_req), .sec_req(sec_req),
    .bus_addr(addr), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rdc(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bad;
    tick(3); rst_n = 1; tick(1);
    // R1 reset state
    rdc("R1 pend0", 12'h000, 0); rdc("R1 pend1", 12'h004, 0);
    rdc("R1 en0", 12'h020, 0);   rdc("R1 en1", 12'h024, 0);
    rdc("R1 spend", 12'h080, 0); rdc("R1 sen", 12'h090, 0);
    rdc("R1 idx", 12'h040, 40);  chk("R1 irq", 32'(irq), 0);
    bad = 0;
    for (int n = 0; n < 40; n++) begin
      addr = 12'h200 + 12'(4 * n); #1;
      if (rdata != 32'(n)) bad++;
    end
    chk("R1 identity map", 32'(bad), 0);

    // R4 R6 R7 R5 vector walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][44]) rdc("R4/R6/R7/R5 vector", VEC[v][43:32], VEC[v][31:0]);
      else wr(VEC[v][43:32], VEC[v][31:0]);
    end
    wr(12'h210, 4);
    // enables now: word0=0x04, word1=0x01, secondary=0xE0

    // R2 rising edge sets pending
    @(negedge clk); pri_req[5] = 1; tick(1);
    rdc("R2 pend5", 12'h000, 32'h20);
    rdc("R5 disabled idx", 12'h040, 40);
    wr(12'h020, 32'h20);
    rdc("R5 idx5", 12'h040, 5);
    chk("R9 irq not yet", 32'(irq), 0);
    tick(1);
    chk("R9 irq high", 32'(irq), 1);

    // R3 clear; held request does not re-set
    wr(12'h010, 32'h20); tick(1);
    rdc("R3 cleared held", 12'h000, 0);
    rdc("R5 none", 12'h040, 40);
    tick(1);
    chk("R9 irq low", 32'(irq), 0);
    wr(12'h010, 32'h0);
    rdc("R3 zero write", 12'h000, 0);
    // R3 set wins over clear
    @(negedge clk); pri_req[5] = 0; tick(1);
    pri_req[5] = 1; addr = 12'h010; wdata = 32'h20; we = 1;
    @(negedge clk); we = 0;
    rdc("R3 set wins", 12'h000, 32'h20);
    wr(12'h010, 32'h20);
    rdc("R3 clear after", 12'h000, 0);

    // R2 second word
    @(negedge clk); pri_req[32] = 1; tick(1);
    rdc("R2 pend32", 12'h004, 32'h1);
    rdc("R5 idx32", 12'h040, 32);

    // R6 remap
    wr(12'h200, 32);
    rdc("R6 chan0 from src32", 12'h040, 0);
    wr(12'h200, 63);
    rdc("R6 out of range", 12'h040, 32);
    wr(12'h200, 0);
    @(negedge clk); pri_req[2] = 1; tick(1);
    rdc("R5 idx2", 12'h040, 2);
    wr(12'h204, 32);
    rdc("R6 chan1 wins", 12'h040, 1);
    wr(12'h204, 1);
    wr(12'h010, 32'h4); wr(12'h014, 32'h1);
    rdc("R3 cleared all", 12'h040, 40);

    // R7 R8 secondary cascade
    @(negedge clk); sec_req[1] = 1; tick(2);
    rdc("R7 disabled spend", 12'h080, 32'h2);
    rdc("R8 no cascade", 12'h000, 0);
    @(negedge clk); sec_req[6] = 1; tick(1);
    rdc("R7 spend6", 12'h080, 32'h42);
    tick(1);
    rdc("R8 cascade pend0", 12'h000, 32'h1);
    wr(12'h020, 32'h1);
    rdc("R5 idx0", 12'h040, 0);
    wr(12'h010, 32'h1);
    rdc("R8 re-set while sec active", 12'h000, 32'h1);
    wr(12'h088, 32'h42);
    rdc("R7 sclear", 12'h080, 0);
    wr(12'h010, 32'h1);
    rdc("R8 clear sticks", 12'h000, 0);
    rdc("R5 final none", 12'h040, 40);
    tick(1);
    chk("R9 irq final", 32'(irq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule